// File: doc/BRIEF.md
# Per-Queue Interrupt Coalescing Dispatcher

This block sits between the completion logic of a multi-queue network interface and its message-signalled interrupt path. Each completion event names a queue and a number of completions. The block keeps a running count for every queue. When that count reaches the queue's packet threshold, it raises one interrupt on the vector the queue is mapped to. The interrupt carries the batch size (the number of completions it covers) together with the message address and data word programmed for that vector.

A global threshold applies to every queue unless a per-queue override is enabled. Low thresholds favour latency and high thresholds favour fewer interrupts. A flush command drains partial batches: every queue holding completions is fired once, in ascending queue order, one per cycle. A vector that is disabled or masked holds back its queues' interrupts, but their counts keep growing. The interrupt leaves through a valid/ready handshake. Events arriving while the handshake is stalled are never lost.

Top module: `coal_irq_dispatch`

## Requirements
- R1: An event with `ev_valid` high adds `ev_count` to the pending count of queue `ev_queue`. The count saturates at 2^CNT_W-1.
- R2: When a queue's pending count is nonzero, at or above its effective threshold, and its vector is usable, one interrupt is issued. That interrupt reports the whole pending count as `irq_batch`, and the queue's count returns to zero.
- R3: The effective threshold of queue q is bits [q*CNT_W +: CNT_W] of `ovr_thresh` when `ovr_en[q]` is 1, and `glb_thresh` otherwise. A threshold of 0 acts as 1.
- R4: `irq_vector` is the map entry `queue_vec_map[q*VEC_W +: VEC_W]` of the fired queue. `irq_addr` and `irq_data` are the slices of `vec_addr` and `vec_data` at that vector's index.
- R5: A vector is usable only when its `vec_enable` bit is 1 and its `vec_mask` bit is 0. Queues on an unusable vector do not fire, keep accumulating, and fire once the vector becomes usable with the count at or above the threshold.
- R6: A one-cycle `flush_req` marks every queue with a nonzero count. Marked queues fire regardless of threshold, in ascending queue order. A marked queue whose vector is unusable is unmarked without firing, and its count is kept.
- R7: While `irq_valid` is 1 and `irq_ready` is 0, the whole interrupt payload holds steady. Events arriving during the stall keep accumulating.
- R8: At most one interrupt is issued per cycle. Among the queues eligible to fire, the lowest queue index wins.
- R9: After reset, `irq_valid` is 0 and every pending count is 0.
- R10: An event arriving in the same cycle that its queue's interrupt is issued is not lost. It starts the queue's next batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Completion event strobe |
| ev_queue | input | QID_W | Queue of the event |
| ev_count | input | CNT_W | Completions in the event |
| flush_req | input | 1 | Drain all partial batches |
| glb_thresh | input | CNT_W | Global packet threshold |
| ovr_en | input | NQ | Per-queue override enables |
| ovr_thresh | input | NQ*CNT_W | Per-queue override thresholds |
| queue_vec_map | input | NQ*VEC_W | Vector index of each queue |
| vec_addr | input | NV*ADDR_W | Message address per vector |
| vec_data | input | NV*DATA_W | Message data per vector |
| vec_enable | input | NV | Vector enable bits |
| vec_mask | input | NV | Vector mask bits |
| irq_valid | output | 1 | Interrupt offered |
| irq_ready | input | 1 | Interrupt taken by the consumer |
| irq_vector | output | VEC_W | Vector of the interrupt |
| irq_batch | output | CNT_W | Completions covered by the interrupt |
| irq_addr | output | ADDR_W | Message address |
| irq_data | output | DATA_W | Message data |

## Verification
The assertions check four properties on every cycle:
- the payload holds steady under back-pressure;
- no interrupt ever carries an empty batch;
- no interrupt is issued on an unusable vector, and an issued queue's count goes to zero unless an event to that queue arrived in the same cycle;
- no lower-indexed eligible queue is passed over.

Other properties depend on a whole sequence of events, and only the bench scenarios can show them:
- the number and sizes of batches under each threshold;
- the ascending flush order;
- the release of a masked queue's batch;
- saturation;
- conservation of every completion across randomized traffic with random stalls.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // Effective threshold: override when enabled, otherwise global; zero acts as one.
  function automatic logic [31:0] eff_thr(input logic use_ovr,
                                          input logic [31:0] ovr,
                                          input logic [31:0] glb);
    logic [31:0] t;
    t = use_ovr ? ovr : glb;
    return (t == 32'd0) ? 32'd1 : t;
  endfunction

  // Saturating add bounded by lim.
  function automatic logic [31:0] sat_add(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input logic [31:0] lim);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, lim}) ? lim : s[31:0];
  endfunction

endpackage

// File: rtl/coal_pend_bank.sv
module coal_pend_bank #(
  parameter int NQ    = 4,
  parameter int CNT_W = 16,
  parameter int QID_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [QID_W-1:0]    ev_qid,
  input  logic [CNT_W-1:0]    ev_cnt,
  input  logic                clr_valid,
  input  logic [QID_W-1:0]    clr_qid,
  output logic [NQ*CNT_W-1:0] pend_flat
);
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [CNT_W-1:0] cnt_r, base, nxt;
    logic             hit, clr;
    always_comb begin
      hit  = ev_valid  && (ev_qid  == QID_W'(q));
      clr  = clr_valid && (clr_qid == QID_W'(q));
      base = clr ? '0 : cnt_r;
      nxt  = hit ? CNT_W'(coal_pkg::sat_add(32'(base), 32'(ev_cnt), CNT_MAX)) : base;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_r <= '0;
      else        cnt_r <= nxt;
    end
    assign pend_flat[q*CNT_W +: CNT_W] = cnt_r;
  end
endmodule

// File: rtl/coal_fire_arb.sv
module coal_fire_arb #(
  parameter int NQ    = 4,
  parameter int NV    = 4,
  parameter int CNT_W = 16,
  parameter int VEC_W = 2,
  parameter int QID_W = 2
) (
  input  logic [NQ*CNT_W-1:0] pend_flat,
  input  logic [CNT_W-1:0]    glb_thresh,
  input  logic [NQ-1:0]       ovr_en,
  input  logic [NQ*CNT_W-1:0] ovr_thresh,
  input  logic [NQ*VEC_W-1:0] queue_vec_map,
  input  logic [NV-1:0]       vec_enable,
  input  logic [NV-1:0]       vec_mask,
  input  logic [NQ-1:0]       flush_mask,
  output logic [NQ-1:0]       nonzero,
  output logic [NQ-1:0]       usable,
  output logic [NQ-1:0]       cand,
  output logic                fire_any,
  output logic [QID_W-1:0]    fire_qid
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [CNT_W-1:0] cnt;
    logic [VEC_W-1:0] vec;
    logic [31:0]      thr;
    assign cnt        = pend_flat[q*CNT_W +: CNT_W];
    assign vec        = queue_vec_map[q*VEC_W +: VEC_W];
    assign thr        = coal_pkg::eff_thr(ovr_en[q], 32'(ovr_thresh[q*CNT_W +: CNT_W]),
                                          32'(glb_thresh));
    assign nonzero[q] = (cnt != '0);
    assign usable[q]  = vec_enable[vec] && !vec_mask[vec];
    assign cand[q]    = nonzero[q] && usable[q] && ((32'(cnt) >= thr) || flush_mask[q]);
  end

  always_comb begin
    fire_any = 1'b0;
    fire_qid = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (cand[q]) begin
        fire_any = 1'b1;
        fire_qid = QID_W'(q);
      end
    end
  end
endmodule

// File: rtl/coal_flush_track.sv
module coal_flush_track #(
  parameter int NQ    = 4,
  parameter int QID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_req,
  input  logic [NQ-1:0]    nonzero,
  input  logic [NQ-1:0]    usable,
  input  logic             clr_valid,
  input  logic [QID_W-1:0] clr_qid,
  output logic [NQ-1:0]    flush_mask
);
  logic [NQ-1:0] clr_oh, nxt;
  always_comb begin
    clr_oh = '0;
    if (clr_valid) clr_oh[clr_qid] = 1'b1;
    nxt = (flush_mask & nonzero & usable & ~clr_oh) | (flush_req ? nonzero : '0);
  end
  always_ff @(posedge clk) begin
    if (!rst_n) flush_mask <= '0;
    else        flush_mask <= nxt;
  end
endmodule

// File: rtl/coal_out_stage.sv
module coal_out_stage #(
  parameter int VEC_W  = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_any,
  input  logic [VEC_W-1:0]  in_vec,
  input  logic [CNT_W-1:0]  in_batch,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              irq_ready,
  output logic              load,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  output logic [CNT_W-1:0]  irq_batch,
  output logic [ADDR_W-1:0] irq_addr,
  output logic [DATA_W-1:0] irq_data
);
  assign load = fire_any && (!irq_valid || irq_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_batch  <= '0;
      irq_addr   <= '0;
      irq_data   <= '0;
    end else begin
      if (load) begin
        irq_valid  <= 1'b1;
        irq_vector <= in_vec;
        irq_batch  <= in_batch;
        irq_addr   <= in_addr;
        irq_data   <= in_data;
      end else if (irq_ready) begin
        irq_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coal_irq_dispatch.sv
module coal_irq_dispatch #(
  parameter int NQ     = 4,
  parameter int NV     = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int VEC_W = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  input  logic [QID_W-1:0]     ev_queue,
  input  logic [CNT_W-1:0]     ev_count,
  input  logic                 flush_req,
  input  logic [CNT_W-1:0]     glb_thresh,
  input  logic [NQ-1:0]        ovr_en,
  input  logic [NQ*CNT_W-1:0]  ovr_thresh,
  input  logic [NQ*VEC_W-1:0]  queue_vec_map,
  input  logic [NV*ADDR_W-1:0] vec_addr,
  input  logic [NV*DATA_W-1:0] vec_data,
  input  logic [NV-1:0]        vec_enable,
  input  logic [NV-1:0]        vec_mask,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [VEC_W-1:0]     irq_vector,
  output logic [CNT_W-1:0]     irq_batch,
  output logic [ADDR_W-1:0]    irq_addr,
  output logic [DATA_W-1:0]    irq_data
);
  // Named internal events for the checker.
  logic [NQ*CNT_W-1:0] pend_flat;
  logic [NQ-1:0]       nonzero, usable, cand, flush_mask;
  logic                fire_any, fire_go, fire_vec_ok;
  logic [QID_W-1:0]    fire_qid;
  logic [VEC_W-1:0]    sel_vec;
  logic [CNT_W-1:0]    sel_batch;
  logic [ADDR_W-1:0]   sel_addr;
  logic [DATA_W-1:0]   sel_data;

  coal_pend_bank #(.NQ(NQ), .CNT_W(CNT_W), .QID_W(QID_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_qid(ev_queue),
    .ev_cnt(ev_count), .clr_valid(fire_go), .clr_qid(fire_qid),
    .pend_flat(pend_flat));

  coal_fire_arb #(.NQ(NQ), .NV(NV), .CNT_W(CNT_W), .VEC_W(VEC_W), .QID_W(QID_W)) arb_i (
    .pend_flat(pend_flat), .glb_thresh(glb_thresh), .ovr_en(ovr_en),
    .ovr_thresh(ovr_thresh), .queue_vec_map(queue_vec_map),
    .vec_enable(vec_enable), .vec_mask(vec_mask), .flush_mask(flush_mask),
    .nonzero(nonzero), .usable(usable), .cand(cand),
    .fire_any(fire_any), .fire_qid(fire_qid));

  coal_flush_track #(.NQ(NQ), .QID_W(QID_W)) flush_i (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .nonzero(nonzero),
    .usable(usable), .clr_valid(fire_go), .clr_qid(fire_qid),
    .flush_mask(flush_mask));

  // Payload of the selected queue.
  always_comb begin
    sel_vec     = queue_vec_map[fire_qid*VEC_W +: VEC_W];
    sel_batch   = pend_flat[fire_qid*CNT_W +: CNT_W];
    sel_addr    = vec_addr[sel_vec*ADDR_W +: ADDR_W];
    sel_data    = vec_data[sel_vec*DATA_W +: DATA_W];
    fire_vec_ok = vec_enable[sel_vec] && !vec_mask[sel_vec];
  end

  coal_out_stage #(.VEC_W(VEC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .fire_any(fire_any), .in_vec(sel_vec),
    .in_batch(sel_batch), .in_addr(sel_addr), .in_data(sel_data),
    .irq_ready(irq_ready), .load(fire_go), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_batch(irq_batch), .irq_addr(irq_addr),
    .irq_data(irq_data));
endmodule

// File: rtl/coal_irq_dispatch_chk.sv
module coal_irq_dispatch_chk #(
  parameter int NQ     = 4,
  parameter int CNT_W  = 16,
  parameter int VEC_W  = 2,
  parameter int QID_W  = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_valid,
  input logic                irq_ready,
  input logic [VEC_W-1:0]    irq_vector,
  input logic [CNT_W-1:0]    irq_batch,
  input logic [ADDR_W-1:0]   irq_addr,
  input logic [DATA_W-1:0]   irq_data,
  input logic                fire_go,
  input logic                fire_vec_ok,
  input logic [QID_W-1:0]    fire_qid,
  input logic [NQ-1:0]       cand,
  input logic                ev_valid,
  input logic [QID_W-1:0]    ev_queue,
  input logic [NQ*CNT_W-1:0] pend_flat
);
  assert_payload_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector) && $stable(irq_batch)
                                && $stable(irq_addr) && $stable(irq_data));

  assert_batch_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_batch != '0);

  assert_usable_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_go |-> fire_vec_ok);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    // R10: an issued queue restarts from zero unless an event joined it that cycle.
    assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire_go && fire_qid == QID_W'(q) && !(ev_valid && ev_queue == QID_W'(q))
      |=> pend_flat[q*CNT_W +: CNT_W] == '0);
    if (q > 0) begin : g_lo
      assert_lowest_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_go && fire_qid == QID_W'(q) |-> cand[q-1:0] == '0);
    end
  end
endmodule

bind coal_irq_dispatch coal_irq_dispatch_chk #(
  .NQ(NQ), .CNT_W(CNT_W), .VEC_W(VEC_W), .QID_W(QID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .irq_batch(irq_batch), .irq_addr(irq_addr),
  .irq_data(irq_data), .fire_go(fire_go), .fire_vec_ok(fire_vec_ok),
  .fire_qid(fire_qid), .cand(cand), .ev_valid(ev_valid), .ev_queue(ev_queue),
  .pend_flat(pend_flat));

// File: tb/coal_irq_dispatch_tb.sv
`timescale 1ns/1ps
module coal_irq_dispatch_tb_top;
  localparam int NQ = 4, NV = 4, CNT_W = 16, AW = 32, DW = 32, QW = 2, VW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, flush_req = 1'b0, irq_ready = 1'b1;
  logic [QW-1:0] ev_queue = '0;
  logic [CNT_W-1:0] ev_count = '0, glb_thresh = 16'd1;
  logic [NQ-1:0] ovr_en = '0;
  logic [NQ*CNT_W-1:0] ovr_thresh = '0;
  logic [NQ*VW-1:0] queue_vec_map;
  logic [NV*AW-1:0] vec_addr;
  logic [NV*DW-1:0] vec_data;
  logic [NV-1:0] vec_enable = '1, vec_mask = '0;
  logic irq_valid;
  logic [VW-1:0] irq_vector;
  logic [CNT_W-1:0] irq_batch;
  logic [AW-1:0] irq_addr;
  logic [DW-1:0] irq_data;

  always #10 clk = ~clk;

  coal_irq_dispatch #(.NQ(NQ), .NV(NV), .CNT_W(CNT_W), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_queue(ev_queue),
    .ev_count(ev_count), .flush_req(flush_req), .glb_thresh(glb_thresh),
    .ovr_en(ovr_en), .ovr_thresh(ovr_thresh), .queue_vec_map(queue_vec_map),
    .vec_addr(vec_addr), .vec_data(vec_data), .vec_enable(vec_enable),
    .vec_mask(vec_mask), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .irq_batch(irq_batch), .irq_addr(irq_addr),
    .irq_data(irq_data));

  int n_checks = 0, n_fail = 0;
  int rec_n = 0;
  int rec_vec [2048];
  int rec_batch [2048];
  logic [31:0] rec_addr [2048];
  logic [31:0] rec_data [2048];

  function automatic logic [31:0] exp_addr(input int v); return 32'hFEE00000 + 32'(16 * v); endfunction
  function automatic logic [31:0] exp_data(input int v); return 32'h00004000 + 32'(v); endfunction

  // Monitor: handshake sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready && rec_n < 2048) begin
      rec_vec[rec_n]   = int'(irq_vector);
      rec_batch[rec_n] = int'(irq_batch);
      rec_addr[rec_n]  = irq_addr;
      rec_data[rec_n]  = irq_data;
      rec_n = rec_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input int q, input int c);
    ev_valid = 1'b1; ev_queue = QW'(q); ev_count = CNT_W'(c);
    tick(1);
    ev_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush_req = 1'b1; tick(1); flush_req = 1'b0;
  endtask

  task automatic set_map_identity();
    for (int i = 0; i < NQ; i++) queue_vec_map[i*VW +: VW] = VW'(i);
  endtask

  task automatic expect_rec(input int idx, input int v, input int b, input string req);
    check(rec_vec[idx] == v, req, rec_vec[idx], v);
    check(rec_batch[idx] == b, req, rec_batch[idx], b);
  endtask

  initial begin : watchdog
    #3_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int base;
    longint sent, got;
    void'($urandom(32'd12345));
    set_map_identity();
    for (int v = 0; v < NV; v++) begin
      vec_addr[v*AW +: AW] = exp_addr(v);
      vec_data[v*DW +: DW] = exp_data(v);
    end
    tick(3);
    check(irq_valid == 1'b0, "R9 reset valid", irq_valid, 0);
    rst_n = 1'b1;
    tick(2);
    check(irq_valid == 1'b0, "R9 idle after reset", irq_valid, 0);

    // R2/R3: threshold 1 -> ten interrupts of batch 1
    glb_thresh = 16'd1; base = rec_n;
    for (int i = 0; i < 10; i++) send(0, 1);
    tick(6);
    check(rec_n - base == 10, "R2 thr1 count", rec_n - base, 10);
    expect_rec(base + 9, 0, 1, "R2 thr1 batch");
    check(rec_addr[base] == exp_addr(0), "R4 addr", rec_addr[base], exp_addr(0));
    check(rec_data[base] == exp_data(0), "R4 data", rec_data[base], exp_data(0));

    // R2/R6: threshold 4 -> two of 4, flush one of 2
    glb_thresh = 16'd4; base = rec_n;
    for (int i = 0; i < 10; i++) send(0, 1);
    tick(6);
    check(rec_n - base == 2, "R2 thr4 count", rec_n - base, 2);
    expect_rec(base, 0, 4, "R2 thr4 batch");
    do_flush(); tick(6);
    check(rec_n - base == 3, "R6 flush count", rec_n - base, 3);
    expect_rec(base + 2, 0, 2, "R6 flush partial");

    // R3: per-queue overrides
    ovr_en = 4'b0011; ovr_thresh[0 +: CNT_W] = 16'd1; ovr_thresh[CNT_W +: CNT_W] = 16'd8;
    base = rec_n;
    for (int i = 0; i < 4; i++) begin send(0, 1); send(1, 1); end
    tick(6);
    check(rec_n - base == 4, "R3 override q0 count", rec_n - base, 4);
    expect_rec(base + 3, 0, 1, "R3 override q0");
    do_flush(); tick(6);
    check(rec_n - base == 5, "R3 override flush count", rec_n - base, 5);
    expect_rec(base + 4, 1, 4, "R3 override q1 flush");
    ovr_en = '0;

    // R5: masked vector holds back, keeps accumulating, releases on unmask
    glb_thresh = 16'd4; vec_mask[2] = 1'b1; base = rec_n;
    for (int i = 0; i < 5; i++) send(2, 1);
    tick(6);
    do_flush(); tick(6);
    check(rec_n - base == 0, "R5 masked silent", rec_n - base, 0);
    vec_mask[2] = 1'b0; tick(6);
    check(rec_n - base == 1, "R5 unmask count", rec_n - base, 1);
    expect_rec(base, 2, 5, "R5 unmask batch");
    check(rec_addr[base] == exp_addr(2), "R4 vec2 addr", rec_addr[base], exp_addr(2));

    // R5: disabled vector behaves like a masked one
    vec_enable[1] = 1'b0; base = rec_n;
    for (int i = 0; i < 6; i++) send(1, 1);
    tick(6);
    check(rec_n - base == 0, "R5 disabled silent", rec_n - base, 0);
    vec_enable[1] = 1'b1; tick(6);
    expect_rec(base, 1, 6, "R5 enable release");

    // R7: stall holds payload, events accumulate
    glb_thresh = 16'd1; irq_ready = 1'b0; base = rec_n;
    send(3, 1); tick(3);
    check(irq_valid == 1'b1, "R7 valid under stall", irq_valid, 1);
    send(3, 1); send(3, 1); tick(3);
    check(irq_batch == 16'd1, "R7 batch held", irq_batch, 1);
    check(irq_vector == 2'd3, "R7 vector held", irq_vector, 3);
    irq_ready = 1'b1; tick(6);
    check(rec_n - base == 2, "R7 drained count", rec_n - base, 2);
    expect_rec(base, 3, 1, "R7 first");
    expect_rec(base + 1, 3, 2, "R7 accumulated");

    // R8: lowest index first once the stall ends
    irq_ready = 1'b0; base = rec_n;
    send(3, 1); send(2, 1); send(1, 1); tick(3);
    irq_ready = 1'b1; tick(6);
    check(rec_n - base == 3, "R8 count", rec_n - base, 3);
    expect_rec(base, 3, 1, "R8 held first");
    expect_rec(base + 1, 1, 1, "R8 lowest next");
    expect_rec(base + 2, 2, 1, "R8 then higher");

    // R6: flush order ascending, threshold ignored
    glb_thresh = 16'd100; base = rec_n;
    send(3, 2); send(1, 3); send(0, 1); tick(4);
    check(rec_n - base == 0, "R6 below threshold", rec_n - base, 0);
    do_flush(); tick(6);
    check(rec_n - base == 3, "R6 flush all", rec_n - base, 3);
    expect_rec(base, 0, 1, "R6 order q0");
    expect_rec(base + 1, 1, 3, "R6 order q1");
    expect_rec(base + 2, 3, 2, "R6 order q3");

    // R4: remapped queue uses its vector's address and data
    queue_vec_map[1*VW +: VW] = 2'd3; glb_thresh = 16'd1; base = rec_n;
    send(1, 1); tick(6);
    expect_rec(base, 3, 1, "R4 remap vector");
    check(rec_addr[base] == exp_addr(3), "R4 remap addr", rec_addr[base], exp_addr(3));
    check(rec_data[base] == exp_data(3), "R4 remap data", rec_data[base], exp_data(3));
    set_map_identity();

    // R1: saturation
    glb_thresh = 16'hFFFF; vec_mask[0] = 1'b1; base = rec_n;
    send(0, 16'hFFFF); send(0, 16'hFFFF); tick(3);
    vec_mask[0] = 1'b0; tick(6);
    check(rec_n - base == 1, "R1 sat count", rec_n - base, 1);
    expect_rec(base, 0, 16'hFFFF, "R1 saturated batch");

    // R3: threshold 0 acts as 1
    glb_thresh = 16'd0; base = rec_n;
    send(2, 1); tick(6);
    check(rec_n - base == 1, "R3 zero thr count", rec_n - base, 1);
    expect_rec(base, 2, 1, "R3 zero thr batch");

    // R10: event in the cycle its queue is issued starts the next batch
    glb_thresh = 16'd2; base = rec_n;
    send(0, 1); send(0, 1); send(0, 1); tick(6);
    check(rec_n - base == 1, "R10 count", rec_n - base, 1);
    expect_rec(base, 0, 2, "R10 batch");
    do_flush(); tick(6);
    expect_rec(base + 1, 0, 1, "R10 carried event");

    // Random traffic: every completion is accounted for (R1, R2, R4, R10)
    glb_thresh = CNT_W'(1 + $urandom_range(0, 5));
    for (int i = 0; i < NQ; i++) ovr_thresh[i*CNT_W +: CNT_W] = CNT_W'($urandom_range(0, 7));
    ovr_en = NQ'($urandom_range(0, 15));
    base = rec_n; sent = 0;
    for (int c = 0; c < 400; c++) begin
      irq_ready = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) vec_mask = NV'($urandom_range(0, 15));
      if ($urandom_range(0, 2) != 0) begin
        ev_valid = 1'b1; ev_queue = QW'($urandom_range(0, NQ - 1));
        ev_count = CNT_W'($urandom_range(1, 3)); sent += ev_count;
      end else ev_valid = 1'b0;
      flush_req = ($urandom_range(0, 30) == 0);
      tick(1);
    end
    ev_valid = 1'b0; flush_req = 1'b0; vec_mask = '0; irq_ready = 1'b1;
    tick(10); do_flush(); tick(12);
    got = 0;
    for (int k = base; k < rec_n; k++) begin
      got += rec_batch[k];
      if (rec_addr[k] != exp_addr(rec_vec[k]))
        check(1'b0, "R4 random addr", rec_addr[k], exp_addr(rec_vec[k]));
    end
    check(got == sent, "R1 R10 random conservation", got, sent);
    check(irq_valid == 1'b0, "R6 random drained", irq_valid, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule